// File: doc/BRIEF.md
# Set-Associative Branch Target Predictor

This block predicts branches for an instruction fetch front end. A table of recently resolved branches is organised as a set-associative cache indexed by the low bits of the physical branch address. Each entry holds a tag, a destination, a flag for branches that always redirect, a short shift register of the branch's own recent outcomes, and a bank of two-bit saturating counters. The history picks one counter, and that counter decides the predicted direction. The lookup port answers in the same cycle from the stored state.

Resolved branches arrive on the update port with their outcome, actual destination and kind. A hit trains the entry. A miss allocates a fresh entry and then trains it. When decode finds a branch that the table missed, the static port applies fixed rules by kind and displacement sign. It returns a direction and destination at once and writes the branch into the table at the next clock edge. Redirecting fetch and flushing wrong-path work are left to the surrounding logic.

Top module: `btp_core`

## Requirements
- R1: After reset no lookup hits. Whenever a lookup misses, `lk_taken` is 0 and `lk_target` is 0.
- R2: A lookup hits when a valid entry in set `lk_addr[IDX_W-1:0]` holds tag `lk_addr[AW-1:IDX_W]`. It then returns that entry's stored destination on `lk_target`.
- R3: On a hit, an entry written with kind 1 (direct jump) or kind 2 (return) predicts taken. Any other entry predicts taken exactly when its counter selected by the entry's history holds 2 or 3.
- R4: An update that hits moves the counter selected by the current history one step toward its outcome, saturating at 0 and 3. The outcome shifts into the history at bit 0. The stored destination is replaced only when the outcome is taken.
- R5: An update that misses allocates an entry with history 0, every counter at 1 and destination `up_target`, and then trains it as in R4.
- R6: A write reuses the way that already holds its address. Otherwise it takes the lowest-numbered invalid way. Otherwise it takes the way of the set written least recently.
- R7: Static direction by `st_kind` (0 conditional, 1 direct jump, 2 return, 3 register-indirect): kinds 1 and 2 are taken, kind 3 is not taken, and kind 0 is taken only when `st_disp` is negative (backward).
- R8: Static destination is `st_addr + st_disp` for kinds 0 and 1, and `st_alt` for kinds 2 and 3.
- R9: A valid static request installs its branch as a fresh entry (history 0, counters at 1) holding the static destination, with the always-taken flag for kinds 1 and 2.
- R10: When update and static requests share a cycle, only the update is written. The static outputs are still produced that cycle.
- R11: A write becomes visible to lookups from the next cycle on, and not in the cycle it is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all valid bits |
| lk_addr | input | AW | Physical fetch address to look up |
| lk_hit | output | 1 | Lookup found an entry |
| lk_taken | output | 1 | Predicted direction |
| lk_target | output | AW | Predicted destination |
| up_valid | input | 1 | Resolved branch present |
| up_addr | input | AW | Resolved branch address |
| up_taken | input | 1 | Resolved outcome |
| up_target | input | AW | Actual destination |
| up_kind | input | 2 | Branch kind (encoding as in R7) |
| st_valid | input | 1 | Static request present; installs the branch |
| st_addr | input | AW | Address of the decoded branch |
| st_kind | input | 2 | Branch kind (encoding as in R7) |
| st_disp | input | AW | Signed relative displacement |
| st_alt | input | AW | Return or register destination |
| st_taken | output | 1 | Static direction |
| st_target | output | AW | Static destination |

## Verification
The bench builds the block with 16-bit addresses, four sets, two ways and a four-bit history. With only two ways per set, replacement of the least recently written way takes a handful of writes. Address collisions are frequent enough for random traffic to hit, train and evict entries many times. A four-bit history still needs four consecutive taken outcomes before the all-ones counter is used, so the saturation and pattern-selection cases are reached in short directed sequences.

// File: rtl/btp_pkg.sv
package btp_pkg;

  typedef enum logic [1:0] {
    BK_COND     = 2'd0,
    BK_DIRECT   = 2'd1,
    BK_RETURN   = 2'd2,
    BK_INDIRECT = 2'd3
  } br_kind_e;

  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

  // Saturating two-bit step toward the outcome.
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic tk);
    if (tk) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic ctr_says_taken(input logic [1:0] c);
    return c[1];
  endfunction

  function automatic logic kind_always_taken(input br_kind_e k);
    return (k == BK_DIRECT) || (k == BK_RETURN);
  endfunction

  // Fixed-rule direction for branches unknown to the table.
  function automatic logic static_dir(input br_kind_e k, input logic backward);
    case (k)
      BK_COND:     return backward;
      BK_DIRECT:   return 1'b1;
      BK_RETURN:   return 1'b1;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic static_uses_alt(input br_kind_e k);
    return (k == BK_RETURN) || (k == BK_INDIRECT);
  endfunction

endpackage

// File: rtl/btp_store.sv
module btp_store #(
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int AW     = 32,
  parameter int HIST_W = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = AW - IDX_W,
  localparam int CTR_W = 2 * (1 << HIST_W)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  // read port A (lookup)
  input  logic [IDX_W-1:0]                  ra_idx,
  output logic [WAYS-1:0]                   ra_vld,
  output logic [WAYS-1:0][TAG_W-1:0]        ra_tag,
  output logic [WAYS-1:0][AW-1:0]           ra_tgt,
  output logic [WAYS-1:0]                   ra_utk,
  output logic [WAYS-1:0][HIST_W-1:0]       ra_hist,
  output logic [WAYS-1:0][CTR_W-1:0]        ra_ctr,
  // read port B (write side)
  input  logic [IDX_W-1:0]                  rb_idx,
  output logic [WAYS-1:0]                   rb_vld,
  output logic [WAYS-1:0][TAG_W-1:0]        rb_tag,
  output logic [WAYS-1:0][AW-1:0]           rb_tgt,
  output logic [WAYS-1:0][HIST_W-1:0]       rb_hist,
  output logic [WAYS-1:0][CTR_W-1:0]        rb_ctr,
  // write port
  input  logic                              we,
  input  logic [IDX_W-1:0]                  w_idx,
  input  logic [WAYS-1:0]                   w_way,
  input  logic [TAG_W-1:0]                  w_tag,
  input  logic [AW-1:0]                     w_tgt,
  input  logic                              w_utk,
  input  logic [HIST_W-1:0]                 w_hist,
  input  logic [CTR_W-1:0]                  w_ctr
);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   utk_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [AW-1:0]     tgt_q  [SETS];
    logic [HIST_W-1:0] hist_q [SETS];
    logic [CTR_W-1:0]  ctr_q  [SETS];

    always_ff @(posedge clk) begin
      if (!rst_n) vld_q <= '0;
      else if (we && w_way[g]) vld_q[w_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we && w_way[g]) begin
        utk_q[w_idx]  <= w_utk;
        tag_q[w_idx]  <= w_tag;
        tgt_q[w_idx]  <= w_tgt;
        hist_q[w_idx] <= w_hist;
        ctr_q[w_idx]  <= w_ctr;
      end
    end

    assign ra_vld[g]  = vld_q[ra_idx];
    assign ra_tag[g]  = tag_q[ra_idx];
    assign ra_tgt[g]  = tgt_q[ra_idx];
    assign ra_utk[g]  = utk_q[ra_idx];
    assign ra_hist[g] = hist_q[ra_idx];
    assign ra_ctr[g]  = ctr_q[ra_idx];

    assign rb_vld[g]  = vld_q[rb_idx];
    assign rb_tag[g]  = tag_q[rb_idx];
    assign rb_tgt[g]  = tgt_q[rb_idx];
    assign rb_hist[g] = hist_q[rb_idx];
    assign rb_ctr[g]  = ctr_q[rb_idx];
  end

endmodule

// File: rtl/btp_lru.sv
module btp_lru #(
  parameter int SETS = 128,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WW    = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] t_idx,
  input  logic [WW-1:0]    t_way,
  input  logic [IDX_W-1:0] q_idx,
  output logic [WW-1:0]    victim
);

  // Per-set recency rank: 0 = newest, WAYS-1 = oldest.
  logic [WAYS-1:0][WW-1:0] rank_q [SETS];
  logic [WAYS-1:0][WW-1:0] t_rank;
  logic [WAYS-1:0][WW-1:0] q_rank;

  assign t_rank = rank_q[t_idx];
  assign q_rank = rank_q[q_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= WW'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == t_way)
          rank_q[t_idx][w] <= '0;
        else if (t_rank[w] < t_rank[t_way])
          rank_q[t_idx][w] <= t_rank[w] + WW'(1);
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (q_rank[w] == WW'(WAYS - 1)) victim = WW'(w);
  end

endmodule

// File: rtl/btp_static.sv
module btp_static #(
  parameter int AW = 32
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] alt,
  output logic          taken,
  output logic [AW-1:0] target
);
  import btp_pkg::*;

  br_kind_e k;
  assign k      = br_kind_e'(kind);
  assign taken  = static_dir(k, disp[AW-1]);
  assign target = static_uses_alt(k) ? alt : pc + disp;

endmodule

// File: rtl/btp_core.sv
module btp_core #(
  parameter int AW     = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int HIST_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic          lk_taken,
  output logic [AW-1:0] lk_target,
  input  logic          up_valid,
  input  logic [AW-1:0] up_addr,
  input  logic          up_taken,
  input  logic [AW-1:0] up_target,
  input  logic [1:0]    up_kind,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_kind,
  input  logic [AW-1:0] st_disp,
  input  logic [AW-1:0] st_alt,
  output logic          st_taken,
  output logic [AW-1:0] st_target
);
  import btp_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - IDX_W;
  localparam int NCTR  = 1 << HIST_W;
  localparam int CTR_W = 2 * NCTR;
  localparam int WW    = $clog2(WAYS);
  localparam logic [CTR_W-1:0] CTR_FRESH = {NCTR{CTR_WEAK_NT}};

  function automatic logic [1:0] ctr_at(input logic [CTR_W-1:0] v, input logic [HIST_W-1:0] h);
    return v[int'(h)*2 +: 2];
  endfunction

  function automatic logic [CTR_W-1:0] ctr_put(input logic [CTR_W-1:0] v,
                                               input logic [HIST_W-1:0] h,
                                               input logic [1:0] c);
    logic [CTR_W-1:0] r;
    r = v;
    r[int'(h)*2 +: 2] = c;
    return r;
  endfunction

  function automatic logic [HIST_W-1:0] hist_push(input logic [HIST_W-1:0] h, input logic tk);
    return {h[HIST_W-2:0], tk};
  endfunction

  // ---------------- storage read ports ----------------
  logic [WAYS-1:0]              ra_vld, ra_utk, rb_vld;
  logic [WAYS-1:0][TAG_W-1:0]   ra_tag, rb_tag;
  logic [WAYS-1:0][AW-1:0]      ra_tgt, rb_tgt;
  logic [WAYS-1:0][HIST_W-1:0]  ra_hist, rb_hist;
  logic [WAYS-1:0][CTR_W-1:0]   ra_ctr, rb_ctr;

  // ---------------- lookup path ----------------
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [WAYS-1:0]   lk_hit_vec;
  logic              lk_utk;
  logic [HIST_W-1:0] lk_hist;
  logic [CTR_W-1:0]  lk_ctr;

  assign lk_idx = lk_addr[IDX_W-1:0];
  assign lk_tag = lk_addr[AW-1:IDX_W];

  always_comb begin
    lk_utk    = 1'b0;
    lk_hist   = '0;
    lk_ctr    = '0;
    lk_target = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_hit_vec[w] = ra_vld[w] && (ra_tag[w] == lk_tag);
      if (lk_hit_vec[w]) begin
        lk_utk    = lk_utk | ra_utk[w];
        lk_hist   = lk_hist | ra_hist[w];
        lk_ctr    = lk_ctr | ra_ctr[w];
        lk_target = lk_target | ra_tgt[w];
      end
    end
  end

  assign lk_hit   = |lk_hit_vec;
  assign lk_taken = lk_hit && (lk_utk || ctr_says_taken(ctr_at(lk_ctr, lk_hist)));

  // ---------------- static rule path ----------------
  btp_static #(.AW(AW)) u_static (
    .kind   (st_kind),
    .pc     (st_addr),
    .disp   (st_disp),
    .alt    (st_alt),
    .taken  (st_taken),
    .target (st_target)
  );

  // ---------------- write path ----------------
  logic             wr_en, wr_from_up, wr_hit, wr_has_inv;
  logic [AW-1:0]    wr_addr;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [WAYS-1:0]  wr_hit_vec, wr_way;
  logic [WW-1:0]    wr_hit_idx, wr_inv_idx, wr_victim, wr_way_idx;

  assign wr_from_up = up_valid;               // update wins a shared cycle
  assign wr_en      = up_valid || st_valid;
  assign wr_addr    = wr_from_up ? up_addr : st_addr;
  assign wr_idx     = wr_addr[IDX_W-1:0];
  assign wr_tag     = wr_addr[AW-1:IDX_W];

  always_comb begin
    wr_hit_idx = '0;
    wr_inv_idx = '0;
    wr_has_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      wr_hit_vec[w] = rb_vld[w] && (rb_tag[w] == wr_tag);
      if (wr_hit_vec[w]) wr_hit_idx = WW'(w);
      if (!rb_vld[w]) begin
        wr_inv_idx = WW'(w);
        wr_has_inv = 1'b1;
      end
    end
  end

  assign wr_hit     = |wr_hit_vec;
  assign wr_way_idx = wr_hit ? wr_hit_idx : (wr_has_inv ? wr_inv_idx : wr_victim);
  assign wr_way     = WAYS'(1) << wr_way_idx;

  btp_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk    (clk),
    .rst_n  (rst_n),
    .touch  (wr_en),
    .t_idx  (wr_idx),
    .t_way  (wr_way_idx),
    .q_idx  (wr_idx),
    .victim (wr_victim)
  );

  // Training of an existing or freshly allocated entry.
  logic [HIST_W-1:0] base_hist, w_hist;
  logic [CTR_W-1:0]  base_ctr, w_ctr;
  logic [AW-1:0]     base_tgt, w_tgt;
  logic              w_utk;
  logic [1:0]        up_ctr_new;

  assign base_hist  = wr_hit ? rb_hist[wr_hit_idx] : '0;
  assign base_ctr   = wr_hit ? rb_ctr[wr_hit_idx]  : CTR_FRESH;
  assign base_tgt   = wr_hit ? rb_tgt[wr_hit_idx]  : up_target;
  assign up_ctr_new = ctr_step(ctr_at(base_ctr, base_hist), up_taken);

  always_comb begin
    if (wr_from_up) begin
      w_hist = hist_push(base_hist, up_taken);
      w_ctr  = ctr_put(base_ctr, base_hist, up_ctr_new);
      w_tgt  = up_taken ? up_target : base_tgt;
      w_utk  = kind_always_taken(br_kind_e'(up_kind));
    end else begin
      w_hist = '0;
      w_ctr  = CTR_FRESH;
      w_tgt  = st_target;
      w_utk  = kind_always_taken(br_kind_e'(st_kind));
    end
  end

  btp_store #(.SETS(SETS), .WAYS(WAYS), .AW(AW), .HIST_W(HIST_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (lk_idx),
    .ra_vld  (ra_vld),
    .ra_tag  (ra_tag),
    .ra_tgt  (ra_tgt),
    .ra_utk  (ra_utk),
    .ra_hist (ra_hist),
    .ra_ctr  (ra_ctr),
    .rb_idx  (wr_idx),
    .rb_vld  (rb_vld),
    .rb_tag  (rb_tag),
    .rb_tgt  (rb_tgt),
    .rb_hist (rb_hist),
    .rb_ctr  (rb_ctr),
    .we      (wr_en),
    .w_idx   (wr_idx),
    .w_way   (wr_way),
    .w_tag   (wr_tag),
    .w_tgt   (w_tgt),
    .w_utk   (w_utk),
    .w_hist  (w_hist),
    .w_ctr   (w_ctr)
  );

endmodule

// File: rtl/btp_checks.sv
module btp_checks #(
  parameter int AW   = 32,
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   lk_addr,
  input logic            lk_hit,
  input logic            lk_taken,
  input logic [AW-1:0]   lk_target,
  input logic            lk_utk,
  input logic            up_valid,
  input logic            st_valid,
  input logic [1:0]      st_kind,
  input logic            st_taken,
  input logic            wr_en,
  input logic            wr_from_up,
  input logic [WAYS-1:0] wr_way,
  input logic [AW-1:0]   wr_addr
);

  a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_taken && lk_target == '0));

  a_r3_fixed_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_utk) |-> lk_taken);

  a_r6_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_way) == 1));

  a_r7_return_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_kind == 2'd2) |-> st_taken);

  a_r7_indirect_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_kind == 2'd3) |-> !st_taken);

  a_r10_update_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && st_valid) |-> wr_from_up);

  a_r11_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (lk_addr != $past(wr_addr) || lk_hit));

endmodule

bind btp_core btp_checks #(.AW(AW), .WAYS(WAYS)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_addr    (lk_addr),
  .lk_hit     (lk_hit),
  .lk_taken   (lk_taken),
  .lk_target  (lk_target),
  .lk_utk     (lk_utk),
  .up_valid   (up_valid),
  .st_valid   (st_valid),
  .st_kind    (st_kind),
  .st_taken   (st_taken),
  .wr_en      (wr_en),
  .wr_from_up (wr_from_up),
  .wr_way     (wr_way),
  .wr_addr    (wr_addr)
);

// File: tb/btp_core_bench.sv
`timescale 1ns/1ps
module btp_core_bench;
  localparam int AW = 16, SETS = 4, WAYS = 2, HIST_W = 4;
  localparam int NCTR = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] lk_addr = '0, up_addr = '0, up_target = '0;
  logic [AW-1:0] st_addr = '0, st_disp = '0, st_alt = '0;
  logic up_valid = 1'b0, up_taken = 1'b0, st_valid = 1'b0;
  logic [1:0] up_kind = '0, st_kind = '0;
  logic lk_hit, lk_taken, st_taken;
  logic [AW-1:0] lk_target, st_target;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  btp_core #(.AW(AW), .SETS(SETS), .WAYS(WAYS), .HIST_W(HIST_W)) u_btp_core (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken),
    .up_target(up_target), .up_kind(up_kind),
    .st_valid(st_valid), .st_addr(st_addr), .st_kind(st_kind),
    .st_disp(st_disp), .st_alt(st_alt), .st_taken(st_taken), .st_target(st_target)
  );

  // ---------------- reference model ----------------
  bit          m_vld  [SETS][WAYS];
  int          m_tag  [SETS][WAYS];
  int          m_tgt  [SETS][WAYS];
  bit          m_fix  [SETS][WAYS];
  int          m_hist [SETS][WAYS];
  int          m_ctr  [SETS][WAYS][NCTR];
  int          m_time [SETS][WAYS];
  int          now_t = 1;

  task automatic m_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_time[s][w] = 0;
      end
  endtask

  task automatic m_lookup(input int a, output bit hit, output bit tk, output int tgt);
    int s, t;
    s = a % SETS; t = a / SETS;
    hit = 0; tk = 0; tgt = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) begin
        hit = 1;
        tgt = m_tgt[s][w];
        tk  = m_fix[s][w] || (m_ctr[s][w][m_hist[s][w]] >= 2);
      end
  endtask

  task automatic m_static(input int kind, input int pc, input int disp, input int alt,
                          output bit tk, output int tgt);
    int rel;
    rel = (pc + disp) % 65536;
    case (kind)
      0: begin tk = (disp >= 32768); tgt = rel; end
      1: begin tk = 1; tgt = rel; end
      2: begin tk = 1; tgt = alt; end
      default: begin tk = 0; tgt = alt; end
    endcase
  endtask

  task automatic m_write();
    int a, s, t, way, oldest, c;
    bit hit, sttk;
    int sttgt;
    if (!up_valid && !st_valid) return;
    a = up_valid ? int'(up_addr) : int'(st_addr);
    s = a % SETS; t = a / SETS;
    way = -1; hit = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) begin way = w; hit = 1; end
    if (way < 0)
      for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[s][w]) way = w;
    if (way < 0) begin
      oldest = 0;
      for (int w = 1; w < WAYS; w++) if (m_time[s][w] < m_time[s][oldest]) oldest = w;
      way = oldest;
    end
    if (!hit || !up_valid) begin
      m_hist[s][way] = 0;
      for (int i = 0; i < NCTR; i++) m_ctr[s][way][i] = 1;
    end
    if (up_valid) begin
      if (!hit) m_tgt[s][way] = int'(up_target);
      c = m_ctr[s][way][m_hist[s][way]];
      c = up_taken ? ((c == 3) ? 3 : c + 1) : ((c == 0) ? 0 : c - 1);
      m_ctr[s][way][m_hist[s][way]] = c;
      m_hist[s][way] = (m_hist[s][way] * 2 + int'(up_taken)) % NCTR;
      if (up_taken) m_tgt[s][way] = int'(up_target);
      m_fix[s][way] = (up_kind == 2'd1) || (up_kind == 2'd2);
    end else begin
      m_static(int'(st_kind), int'(st_addr), int'(st_disp), int'(st_alt), sttk, sttgt);
      m_tgt[s][way] = sttgt;
      m_fix[s][way] = (st_kind == 2'd1) || (st_kind == 2'd2);
    end
    m_vld[s][way] = 1; m_tag[s][way] = t;
    m_time[s][way] = now_t; now_t++;
  endtask

  // ---------------- checking helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    up_valid = 0; st_valid = 0;
  endtask

  // One clock: compare combinational outputs against the model, then advance both.
  task automatic cycle();
    bit h, tk, stk; int tg, stg;
    #1;
    m_lookup(int'(lk_addr), h, tk, tg);
    check("R2 lookup hit", int'(lk_hit), int'(h));
    check("R3 lookup direction", int'(lk_taken), int'(tk));
    check("R2 lookup target", int'(lk_target), tg);
    m_static(int'(st_kind), int'(st_addr), int'(st_disp), int'(st_alt), stk, stg);
    check("R7 static direction", int'(st_taken), int'(stk));
    check("R8 static target", int'(st_target), stg);
    @(posedge clk);
    m_write();
    @(negedge clk);
  endtask

  task automatic peek(input logic [AW-1:0] a, input string req,
                      input bit eh, input bit et, input int etg);
    idle(); lk_addr = a; #1;
    check(req, int'(lk_hit), int'(eh));
    check(req, int'(lk_taken), int'(et));
    check(req, int'(lk_target), etg);
    cycle();
  endtask

  task automatic do_up(input logic [AW-1:0] a, input bit tk, input logic [AW-1:0] tg,
                       input logic [1:0] k);
    idle(); up_valid = 1; up_addr = a; up_taken = tk; up_target = tg; up_kind = k;
    cycle(); idle();
  endtask

  task automatic do_st(input logic [AW-1:0] a, input logic [1:0] k, input logic [AW-1:0] d,
                       input logic [AW-1:0] alt, input string req, input bit et, input int etg);
    idle(); st_valid = 1; st_addr = a; st_kind = k; st_disp = d; st_alt = alt; #1;
    check(req, int'(st_taken), int'(et));
    check(req, int'(st_target), etg);
    cycle(); idle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: empty after reset
    for (int i = 0; i < 8; i++) peek(AW'(i * 37), "R1 empty after reset", 0, 0, 0);

    // R7 / R8 / R9: static rules, each install overwrites entry 0x0100
    do_st(16'h0100, 2'd0, 16'hFFF0, 16'h1111, "R7 R8 cond backward", 1, 16'h00F0);
    do_st(16'h0100, 2'd0, 16'h0020, 16'h1111, "R7 R8 cond forward", 0, 16'h0120);
    peek(16'h0100, "R9 fresh entry weakly not taken", 1, 0, 16'h0120);
    do_st(16'h0100, 2'd1, 16'h0020, 16'h1111, "R7 R8 direct jump", 1, 16'h0120);
    peek(16'h0100, "R9 direct entry always taken", 1, 1, 16'h0120);
    do_st(16'h0100, 2'd2, 16'h0020, 16'h4444, "R7 R8 return", 1, 16'h4444);
    do_st(16'h0100, 2'd3, 16'hFF00, 16'h5555, "R7 R8 indirect", 0, 16'h5555);
    peek(16'h0100, "R9 indirect entry by counter", 1, 0, 16'h5555);

    // R11: install not visible in its own cycle
    idle(); st_valid = 1; st_addr = 16'h0203; st_kind = 2'd1; st_disp = 16'h0010;
    lk_addr = 16'h0203; #1;
    check("R11 same-cycle lookup misses", int'(lk_hit), 0);
    cycle(); idle();
    peek(16'h0203, "R11 visible next cycle", 1, 1, 16'h0213);

    // R5 / R4 / R3: training on a conditional branch
    do_up(16'h0302, 1, 16'h0AAA, 2'd0);
    peek(16'h0302, "R5 miss allocates and trains", 1, 0, 16'h0AAA);
    for (int i = 0; i < 4; i++) do_up(16'h0302, 1, 16'h0AAA, 2'd0);
    peek(16'h0302, "R3 R4 all-ones history counter taken", 1, 1, 16'h0AAA);
    do_up(16'h0302, 0, 16'h0BBB, 2'd0);
    peek(16'h0302, "R4 not-taken keeps target", 1, 0, 16'h0AAA);

    // R6: replacement in set 1
    do_up(16'h1001, 1, 16'h0A01, 2'd0);
    do_up(16'h2001, 1, 16'h0B01, 2'd0);
    do_up(16'h1001, 1, 16'h0A01, 2'd0);
    do_up(16'h3001, 1, 16'h0C01, 2'd0);
    peek(16'h2001, "R6 oldest way evicted", 0, 0, 0);
    peek(16'h1001, "R6 recently written way kept", 1, 0, 16'h0A01);
    peek(16'h3001, "R6 new entry present", 1, 0, 16'h0C01);

    // R10: shared cycle, update wins
    idle(); up_valid = 1; up_addr = 16'h0403; up_taken = 1; up_target = 16'h0D03;
    up_kind = 2'd1; st_valid = 1; st_addr = 16'h0507; st_kind = 2'd1; st_disp = 16'h0002;
    cycle(); idle();
    peek(16'h0507, "R10 static install dropped", 0, 0, 0);
    peek(16'h0403, "R10 update written", 1, 1, 16'h0D03);

    // Random traffic against the model (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 600; i++) begin
      lk_addr   = AW'(($urandom_range(0, 5) << 2) | $urandom_range(0, 3));
      up_valid  = ($urandom_range(0, 9) < 4);
      up_addr   = AW'(($urandom_range(0, 5) << 2) | $urandom_range(0, 3));
      up_taken  = $urandom_range(0, 1);
      up_target = AW'($urandom);
      up_kind   = 2'($urandom_range(0, 3));
      st_valid  = ($urandom_range(0, 9) < 3);
      st_addr   = AW'(($urandom_range(0, 5) << 2) | $urandom_range(0, 3));
      st_kind   = 2'($urandom_range(0, 3));
      st_disp   = AW'($urandom);
      st_alt    = AW'($urandom);
      cycle();
    end
    idle();

    // R1: reset again clears everything
    rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1; m_clear();
    for (int i = 0; i < 24; i++) peek(AW'(i), "R1 cleared by reset", 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule